// File: doc/BRIEF.md
# Addressing-Mode Operand Resolver

This block turns the operand field of a load instruction into the data value that the load delivers. The sequencer gives it an 8-bit operand, a 2-bit addressing-mode code and the current index register value, and raises `start_i`. The resolver then issues as many memory reads as the mode needs. That is none for immediate, one for direct and indexed, and two chained reads for indirect. It then pulses `done_o` with the value on `result_o`.

The memory side is a plain request/valid read port with a fixed latency of one cycle. Each request is a one-cycle `rd_req_o` pulse with `rd_addr_o`. The matching `rd_valid_i`/`rd_data_i` arrive in the following cycle. Stores, arithmetic and instruction fetch are handled elsewhere.

Top module: `operand_resolver`

## Requirements
- R1: Mode 2'b00 (immediate): `done_o` is high in the cycle right after the edge that accepts `start_i`, `result_o` equals the operand, and no read is issued.
- R2: Mode 2'b01 (direct): exactly one read is issued, at address equal to the operand, and the returned word becomes the result. `done_o` rises two cycles after the accepting edge.
- R3: Mode 2'b10 (indirect): a first read at the operand address is followed by a second read whose address is the word returned by the first. The word from the second read is the result, with `done_o` three cycles after the accepting edge.
- R4: Mode 2'b11 (indexed): one read is issued at (operand + index) modulo 256, and the returned word is the result. `done_o` rises two cycles after the accepting edge.
- R5: `done_o` is a single-cycle pulse per accepted load. `result_o` keeps its value until the next load completes.
- R6: A `start_i` seen while a load is in progress is ignored. It starts no read and changes neither the result nor the number of `done_o` pulses.
- R7: After reset `done_o` and `rd_req_o` are low and `result_o` is zero.
- R8: With memory holding 51→54, 52→135, 53→172, 54→201, 55→52 and 56→89, the resolver returns 89 for direct 56, 135 for indirect 55 and 172 for indexed 51 with index 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin resolving the presented operand |
| mode_i | input | 2 | Addressing mode: 00 immediate, 01 direct, 10 indirect, 11 indexed |
| operand_i | input | 8 | Operand field of the instruction |
| index_i | input | 8 | Current index register value |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 8 | Resolved data value |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 8 | Memory read address |
| rd_valid_i | input | 1 | Read data valid, one cycle after the request |
| rd_data_i | input | 8 | Read data |

## Verification
The bench checks the published memory image first. A resolver that returned the first word of an indirect load would give 52 instead of 135, and one that ignored the index would give 54 instead of 172. An indexed sum that crosses 255 is driven to catch an adder that carries into a ninth bit or saturates, which would read the wrong word. Starts are pulsed in the middle of an indirect load to expose a sequencer that restarts, which shows up as an extra read, an extra done pulse or a corrupted result. Every load also has its latency and read count measured, so a mode that takes a wrong number of memory accesses is caught even when its data happen to match.

// File: rtl/operand_resolver.sv
module operand_resolver #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] operand_i,
  input  logic [AW-1:0] index_i,
  output logic          done_o,
  output logic [AW-1:0] result_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_data_i
);

  localparam logic [1:0] M_IMM = 2'b00, M_DIR = 2'b01, M_IND = 2'b10, M_IDX = 2'b11;
  localparam logic [1:0] S_IDLE = 2'd0, S_ISSUE = 2'd1, S_WAIT1 = 2'd2, S_WAIT2 = 2'd3;

  logic [1:0]    state_q;
  logic [AW-1:0] addr_q;
  logic          ind_q;

  wire idle     = state_q == S_IDLE;
  wire chain    = state_q == S_WAIT1 && rd_valid_i && ind_q;
  wire finish   = rd_valid_i && ((state_q == S_WAIT1 && !ind_q) || state_q == S_WAIT2);

  assign rd_req_o  = (state_q == S_ISSUE) || chain;
  assign rd_addr_o = chain ? rd_data_i : addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      ind_q    <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          if (mode_i == M_IMM) begin
            result_o <= operand_i;
            done_o   <= 1'b1;
          end else begin
            state_q <= S_ISSUE;
            addr_q  <= (mode_i == M_IDX) ? operand_i + index_i : operand_i;
            ind_q   <= mode_i == M_IND;
          end
        end
        S_ISSUE: state_q <= S_WAIT1;
        S_WAIT1: if (chain) state_q <= S_WAIT2;
        default: ;
      endcase
      if (finish) begin
        result_o <= rd_data_i;
        done_o   <= 1'b1;
        state_q  <= S_IDLE;
      end
    end
  end

  wire unused_ok = &{1'b0, M_DIR};

endmodule

// File: rtl/operand_resolver_chk.sv
module operand_resolver_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [1:0]    mode_i,
  input logic [AW-1:0] operand_i,
  input logic [AW-1:0] index_i,
  input logic          done_o,
  input logic [AW-1:0] result_o,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_valid_i,
  input logic [AW-1:0] rd_data_i,
  input logic [1:0]    state_q
);

  wire accept = state_q == 2'd0 && start_i;

  p_imm_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_i == 2'b00 |=> done_o && result_o == $past(operand_i) && !rd_req_o);

  p_idle_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == 2'd0 |-> !rd_req_o);

  p_direct_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_i == 2'b01 |=> rd_req_o && rd_addr_o == $past(operand_i));

  p_indirect_chain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == 2'd2 && rd_req_o |=> state_q == 2'd3 && !done_o);

  p_index_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && mode_i == 2'b11 |=> rd_req_o && rd_addr_o == AW'($past(operand_i) + $past(index_i)));

  p_result_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o && $past(rst_n) |-> $stable(result_o));

  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == 2'd1 |=> state_q == 2'd2);

endmodule

bind operand_resolver operand_resolver_chk #(.AW(AW)) u_chk (.*);

// File: tb/operand_resolver_tb.sv
module operand_resolver_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [7:0] operand_i = '0, index_i = '0;
  logic       done_o, rd_req_o, rd_valid_i;
  logic [7:0] result_o, rd_addr_o, rd_data_i;

  int tests = 0, fails = 0, nreq = 0, ndone = 0;
  logic [7:0] mem [256];

  always #2 clk = ~clk;

  operand_resolver u_dut (.*);

  always_ff @(posedge clk) begin
    rd_valid_i <= rd_req_o;
    rd_data_i  <= mem[rd_addr_o];
  end
  always @(posedge clk) begin
    if (rd_req_o) nreq++;
    if (done_o) ndone++;
  end

  function automatic logic [7:0] expect_val(logic [1:0] m, logic [7:0] op, logic [7:0] ix);
    case (m)
      2'b00: return op;
      2'b01: return mem[op];
      2'b10: return mem[mem[op]];
      default: return mem[8'(op + ix)];
    endcase
  endfunction

  function automatic int expect_lat(logic [1:0] m);
    return m == 2'b00 ? 0 : m == 2'b10 ? 3 : 2;
  endfunction

  function automatic int expect_rd(logic [1:0] m);
    return m == 2'b00 ? 0 : m == 2'b10 ? 2 : 1;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string rq(logic [1:0] m);
    return m == 2'b00 ? "R1" : m == 2'b01 ? "R2" : m == 2'b10 ? "R3" : "R4";
  endfunction

  task automatic load(logic [1:0] m, logic [7:0] op, logic [7:0] ix, output logic [7:0] res, output int lat);
    nreq = 0;
    @(negedge clk);
    start_i = 1'b1; mode_i = m; operand_i = op; index_i = ix;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 20) begin @(negedge clk); lat++; end
    res = result_o;
  endtask

  task automatic run(logic [1:0] m, logic [7:0] op, logic [7:0] ix);
    logic [7:0] res; int lat;
    load(m, op, ix, res, lat);
    check(rq(m), res, expect_val(m, op, ix));
    check(rq(m), lat, expect_lat(m));
    @(negedge clk);
    check(rq(m), nreq, expect_rd(m));
  endtask

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] res, hold; int lat, d0;
    void'($urandom(1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
    mem[51] = 54; mem[52] = 135; mem[53] = 172; mem[54] = 201; mem[55] = 52; mem[56] = 89;

    repeat (3) @(negedge clk);
    check("R7 done", done_o, 0);
    check("R7 req", rd_req_o, 0);
    check("R7 result", result_o, 0);
    rst_n = 1'b1;

    load(2'b01, 56, 0, res, lat); check("R8 direct 56", res, 89);
    load(2'b10, 55, 0, res, lat); check("R8 indirect 55", res, 135);
    load(2'b11, 51, 2, res, lat); check("R8 indexed 51+2", res, 172);
    run(2'b00, 8'd13, 0);
    run(2'b11, 8'd250, 8'd10);
    run(2'b11, 8'd255, 8'd255);
    run(2'b10, 8'd0, 0);

    d0 = ndone;
    hold = result_o;
    repeat (4) @(negedge clk);
    check("R5 no spurious done", ndone - d0, 0);
    check("R5 result held", result_o, hold);

    d0 = ndone; nreq = 0;
    @(negedge clk);
    start_i = 1'b1; mode_i = 2'b10; operand_i = 55;
    @(negedge clk);
    mode_i = 2'b00; operand_i = 8'hEE;
    @(negedge clk);
    mode_i = 2'b01; operand_i = 56;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 result", result_o, 135);
    check("R6 reads", nreq, 2);
    check("R6 done count", ndone - d0, 1);

    d0 = ndone;
    run(2'b01, 8'd7, 0);
    check("R5 one pulse", ndone - d0, 1);

    for (int k = 0; k < 300; k++) begin
      logic [1:0] m; logic [7:0] op, ix;
      m = 2'($urandom); op = 8'($urandom); ix = 8'($urandom);
      run(m, op, ix);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule